// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller-facing end of a byte-wide mailbox that a host uses to reach a 256-byte register space held inside the controller. The host sees two byte ports. Offset 0x0 is the data port. Offset 0x4 returns a status byte when read and takes a command byte when written. Every byte the host writes raises an input-full flag. A small sequencer consumes the byte a fixed number of cycles later, and the flag then drops. When a result is ready, the sequencer loads it into the data port and raises an output-full flag. A host read of the data port drops that flag again.

The sequencer decodes five commands. Read (0x80) takes one address byte and returns the register value. Write (0x81) takes an address byte and then a data byte. Burst enable (0x82) and burst disable (0x83) only change a mode bit. Query (0x84) returns the code of a pending event, and the event itself is posted by logic next to the block through a one-cycle strobe. The host is expected to wait for input-full to clear before it writes each byte. It is also expected to wait for output-full before it reads a result.

Top module: `ec_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, and every location of the register space reads back as 0x00.
- R2: A host write to offset 0x0 or 0x4 while input-full is clear sets input-full (status bit 1) on the next clock. Input-full stays set for exactly CONSUME_LAT cycles and then clears. Status bit 3 reads 1 when the last accepted byte went to offset 0x4 and 0 when it went to offset 0x0. Writes to any other offset are ignored.
- R3: A host write made while input-full is set is dropped and does not replace the pending byte.
- R4: Command 0x80 followed by an address byte places the register value at that address on the data port. Output-full (status bit 0) sets two cycles after the address byte is consumed.
- R5: Command 0x81 followed by an address byte and a data byte stores the data byte at that address.
- R6: A host read strobe on offset 0x0 clears output-full on the next clock.
- R7: Command 0x82 sets the burst bit (status bit 4), and command 0x83 clears it. Neither command sets output-full.
- R8: An event strobe sets the event-pending bit (status bit 5) and records its code. Command 0x84 loads that code onto the data port, or 0x00 when no event is pending, sets output-full and clears event-pending.
- R9: An unknown command byte is consumed and ignored. The sequencer returns to idle, so a following data byte produces no output.
- R10: A command byte that arrives in the middle of a sequence abandons that sequence and starts the new command.
- R11: A data byte that arrives while no command is waiting for one is consumed without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host byte write strobe |
| host_rd_i | input | 1 | Host byte read strobe |
| host_addr_i | input | HOST_AW | Host port offset (0x0 data, 0x4 status/command) |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte for the offset on host_addr_i |
| evt_set_i | input | 1 | Event post strobe |
| evt_code_i | input | 8 | Event code that goes with the strobe |

## Verification
The bench writes every register location through the full command protocol and reads each one back. An address/data mix-up or a lost byte would therefore show up as a wrong value at some location. It times the input-full flag and the read result to the exact cycle, so a sequencer one cycle too fast or too slow is caught. It also tries to overwrite a pending byte. A design that accepted that byte would return the register at the wrong address. Further cases cover an unknown command followed by data, a command that cuts into a write sequence, a stray data byte while idle, and a second query after the event was drained. A design that decoded any of these wrongly would raise output-full when it should not, clobber a register, or hand back a stale event code.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ADDR,
    S_RD_WAIT,
    S_WR_ADDR,
    S_WR_DATA
  } seq_state_e;

  localparam logic [7:0] CMD_READ      = 8'h80;
  localparam logic [7:0] CMD_WRITE     = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY     = 8'h84;

  localparam int STS_OBF   = 0;
  localparam int STS_IBF   = 1;
  localparam int STS_CMD   = 3;
  localparam int STS_BURST = 4;
  localparam int STS_EVT   = 5;
endpackage

// File: rtl/ec_regfile.sv
module ec_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[addr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ec_host_if.sv
module ec_host_if
  import ec_mbox_pkg::*;
#(
  parameter int HOST_AW     = 3,
  parameter int CONSUME_LAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [7:0]         host_wdata_i,
  output logic [7:0]         host_rdata_o,
  output logic               in_valid_o,
  output logic [7:0]         in_byte_o,
  output logic               in_is_cmd_o,
  input  logic               out_load_i,
  input  logic [7:0]         out_byte_i,
  input  logic               burst_i,
  input  logic               evt_pend_i
);
  localparam int CW = (CONSUME_LAT > 1) ? $clog2(CONSUME_LAT) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONSUME_LAT - 1);
  localparam logic [HOST_AW-1:0] OFS_DATA = HOST_AW'(0);
  localparam logic [HOST_AW-1:0] OFS_CTRL = HOST_AW'(4);

  logic          ibf_q, obf_q, cmd_q;
  logic [7:0]    in_byte_q, out_byte_q;
  logic [CW-1:0] cnt_q;
  logic          at_data, at_ctrl, accept, consume;
  logic [7:0]    status;

  assign at_data = (host_addr_i == OFS_DATA);
  assign at_ctrl = (host_addr_i == OFS_CTRL);
  assign accept  = host_wr_i && (at_data || at_ctrl) && !ibf_q;
  assign consume = ibf_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ibf_q     <= 1'b0;
      cmd_q     <= 1'b0;
      in_byte_q <= '0;
      cnt_q     <= '0;
    end else if (accept) begin
      ibf_q     <= 1'b1;
      cmd_q     <= at_ctrl;
      in_byte_q <= host_wdata_i;
      cnt_q     <= '0;
    end else if (consume) begin
      ibf_q <= 1'b0;
    end else if (ibf_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // load wins over a same-cycle host read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_q      <= 1'b0;
      out_byte_q <= '0;
    end else if (out_load_i) begin
      obf_q      <= 1'b1;
      out_byte_q <= out_byte_i;
    end else if (host_rd_i && at_data) begin
      obf_q <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[STS_OBF]   = obf_q;
    status[STS_IBF]   = ibf_q;
    status[STS_CMD]   = cmd_q;
    status[STS_BURST] = burst_i;
    status[STS_EVT]   = evt_pend_i;
  end

  assign host_rdata_o = at_data ? out_byte_q : (at_ctrl ? status : 8'h00);
  assign in_valid_o   = consume;
  assign in_byte_o    = in_byte_q;
  assign in_is_cmd_o  = cmd_q;

  // R2
  ibf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && at_ctrl && !ibf_q) |=> (ibf_q && cmd_q));
  // R3
  wr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && ibf_q) |=> $stable(in_byte_q));
  // R6
  obf_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && at_data && !out_load_i) |=> !obf_q);
  // R4
  obf_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_load_i |=> (obf_q && out_byte_q == $past(out_byte_i)));
endmodule

// File: rtl/ec_cmd_seq.sv
module ec_cmd_seq
  import ec_mbox_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_byte_i,
  input  logic              in_is_cmd_i,
  input  logic              evt_set_i,
  input  logic [7:0]        evt_code_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [REG_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              out_load_o,
  output logic [7:0]        out_byte_o,
  output logic              burst_o,
  output logic              evt_pend_o
);
  seq_state_e        state_q, state_d;
  logic [REG_AW-1:0] addr_q;
  logic              burst_q, evt_pend_q;
  logic [7:0]        evt_code_q;
  logic              cmd_in, data_in, query;

  assign cmd_in  = in_valid_i && in_is_cmd_i;
  assign data_in = in_valid_i && !in_is_cmd_i;
  assign query   = cmd_in && (in_byte_i == CMD_QUERY);

  always_comb begin
    state_d = state_q;
    if (cmd_in) begin
      case (in_byte_i)
        CMD_READ:  state_d = S_RD_ADDR;
        CMD_WRITE: state_d = S_WR_ADDR;
        default:   state_d = S_IDLE;
      endcase
    end else begin
      case (state_q)
        S_RD_ADDR: if (data_in) state_d = S_RD_WAIT;
        S_RD_WAIT: state_d = S_IDLE;
        S_WR_ADDR: if (data_in) state_d = S_WR_DATA;
        S_WR_DATA: if (data_in) state_d = S_IDLE;
        default:   state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      burst_q    <= 1'b0;
      evt_pend_q <= 1'b0;
      evt_code_q <= '0;
    end else begin
      state_q <= state_d;
      if (data_in && state_q == S_WR_ADDR) addr_q <= in_byte_i[REG_AW-1:0];
      if (cmd_in && in_byte_i == CMD_BURST_ON)  burst_q <= 1'b1;
      if (cmd_in && in_byte_i == CMD_BURST_OFF) burst_q <= 1'b0;
      if (query) evt_pend_q <= 1'b0;
      // a new post in the query cycle stays pending
      if (evt_set_i) begin
        evt_pend_q <= 1'b1;
        evt_code_q <= evt_code_i;
      end
    end
  end

  assign mem_re_o    = data_in && (state_q == S_RD_ADDR);
  assign mem_we_o    = data_in && (state_q == S_WR_DATA);
  assign mem_addr_o  = (state_q == S_WR_DATA) ? addr_q : in_byte_i[REG_AW-1:0];
  assign mem_wdata_o = in_byte_i;
  assign out_load_o  = (state_q == S_RD_WAIT) || query;
  assign out_byte_o  = (state_q == S_RD_WAIT) ? mem_rdata_i
                     : (evt_pend_q ? evt_code_q : 8'h00);
  assign burst_o     = burst_q;
  assign evt_pend_o  = evt_pend_q;

  // R4
  rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_WAIT) |-> !in_valid_i);
  // R7
  burst_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_in && in_byte_i == CMD_BURST_ON) |=> burst_q);
  // R8
  evt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query && !evt_set_i) |=> !evt_pend_q);
  // R9
  unk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_in && in_byte_i != CMD_READ && in_byte_i != CMD_WRITE) |=> (state_q == S_IDLE));
  // R10
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_in && in_byte_i == CMD_READ) |=> (state_q == S_RD_ADDR));
endmodule

// File: rtl/ec_mailbox.sv
module ec_mailbox
  import ec_mbox_pkg::*;
#(
  parameter int HOST_AW     = 3,
  parameter int REG_AW      = 8,
  parameter int CONSUME_LAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_wr_i,
  input  logic               host_rd_i,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [7:0]         host_wdata_i,
  output logic [7:0]         host_rdata_o,
  input  logic               evt_set_i,
  input  logic [7:0]         evt_code_i
);
  logic              in_valid, in_is_cmd, out_load, burst, evt_pend;
  logic [7:0]        in_byte, out_byte, mem_rdata, mem_wdata;
  logic              mem_re, mem_we;
  logic [REG_AW-1:0] mem_addr;

  ec_host_if #(.HOST_AW(HOST_AW), .CONSUME_LAT(CONSUME_LAT)) u_host (
    .clk_i, .rst_ni, .host_wr_i, .host_rd_i, .host_addr_i, .host_wdata_i,
    .host_rdata_o,
    .in_valid_o (in_valid),
    .in_byte_o  (in_byte),
    .in_is_cmd_o(in_is_cmd),
    .out_load_i (out_load),
    .out_byte_i (out_byte),
    .burst_i    (burst),
    .evt_pend_i (evt_pend)
  );

  ec_cmd_seq #(.REG_AW(REG_AW)) u_seq (
    .clk_i, .rst_ni,
    .in_valid_i (in_valid),
    .in_byte_i  (in_byte),
    .in_is_cmd_i(in_is_cmd),
    .evt_set_i, .evt_code_i,
    .mem_rdata_i(mem_rdata),
    .mem_re_o   (mem_re),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_wdata_o(mem_wdata),
    .out_load_o (out_load),
    .out_byte_o (out_byte),
    .burst_o    (burst),
    .evt_pend_o (evt_pend)
  );

  ec_regfile #(.AW(REG_AW), .DW(8)) u_regs (
    .clk_i, .rst_ni,
    .re_i   (mem_re),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );
endmodule

// File: tb/sim_ec_mailbox.sv
module sim_ec_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, evt_set = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00, evt_code = 8'h00, rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ec_mailbox #(.HOST_AW(3), .REG_AW(8), .CONSUME_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .evt_set_i(evt_set), .evt_code_i(evt_code)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic status(output logic [7:0] s);
    addr = 3'd4; #1 s = rdata;
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); status(s);
      if (!s[1]) return;
    end
    chk("R2 ibf stuck", 8'h01, 8'h00);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] b);
    wait_ibf_clear();
    addr = a; wdata = b; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd_data(output logic [7:0] d);
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      status(s);
      if (s[0]) break;
      @(negedge clk);
    end
    if (!s[0]) chk("R4 obf never set", 8'h00, 8'h01);
    addr = 3'd0; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ec_read(input logic [7:0] a, output logic [7:0] d);
    host_wr(3'd4, 8'h80);
    host_wr(3'd0, a);
    host_rd_data(d);
  endtask

  task automatic ec_write(input logic [7:0] a, input logic [7:0] d);
    host_wr(3'd4, 8'h81);
    host_wr(3'd0, a);
    host_wr(3'd0, d);
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    status(s); chk("R1 status after reset", s, 8'h00);
    ec_read(8'h05, d); chk("R1 register after reset", d, 8'h00);

    // R2 exact input-full timing with a command byte
    wait_ibf_clear();
    addr = 3'd4; wdata = 8'h83; wr = 1'b1;
    @(negedge clk); wr = 1'b0; status(s);
    chk("R2 ibf set", s & 8'h0A, 8'h0A);
    @(negedge clk); status(s); chk("R2 ibf held", s & 8'h02, 8'h02);
    @(negedge clk); status(s); chk("R2 ibf cleared after LAT", s & 8'h02, 8'h00);
    // R2 write to unused offset ignored
    addr = 3'd2; wdata = 8'h80; wr = 1'b1;
    @(negedge clk); wr = 1'b0; status(s);
    chk("R2 unused offset", s & 8'h0A, 8'h08);
    // R2 data write clears the command bit
    host_wr(3'd0, 8'h11);
    status(s); chk("R2 cmd bit after data", s & 8'h0A, 8'h02);
    wait_ibf_clear();

    // R5 sweep: write every location
    for (int a = 0; a < 256; a++) ec_write(8'(a), pat(a));
    // R4 sweep: read every location back
    for (int a = 0; a < 256; a++) begin
      ec_read(8'(a), d);
      chk($sformatf("R5 readback %0d", a), d, pat(a));
    end

    // R4 cycle-exact read result, R6 clear
    host_wr(3'd4, 8'h80);
    wait_ibf_clear();
    addr = 3'd0; wdata = 8'h20; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk);
    @(negedge clk); status(s); chk("R4 obf not yet", s & 8'h01, 8'h00);
    @(negedge clk); status(s); chk("R4 obf set on time", s & 8'h01, 8'h01);
    addr = 3'd0; #1 chk("R4 read value", rdata, pat(32));
    rd = 1'b1;
    @(negedge clk); rd = 1'b0; status(s);
    chk("R6 obf cleared by read", s & 8'h01, 8'h00);

    // R3 write while input-full dropped
    host_wr(3'd4, 8'h80);
    wait_ibf_clear();
    addr = 3'd0; wdata = 8'h10; wr = 1'b1;
    @(negedge clk); wdata = 8'h30;
    @(negedge clk); wr = 1'b0;
    host_rd_data(d); chk("R3 dropped byte", d, pat(16));

    // R7 burst
    host_wr(3'd4, 8'h82); wait_ibf_clear(); status(s);
    chk("R7 burst on", s & 8'h11, 8'h10);
    host_wr(3'd4, 8'h83); wait_ibf_clear(); status(s);
    chk("R7 burst off", s & 8'h11, 8'h00);

    // R8 query
    host_wr(3'd4, 8'h84); host_rd_data(d); chk("R8 query empty", d, 8'h00);
    evt_code = 8'h5A; evt_set = 1'b1;
    @(negedge clk); evt_set = 1'b0; status(s);
    chk("R8 event pending", s & 8'h20, 8'h20);
    host_wr(3'd4, 8'h84); host_rd_data(d); chk("R8 query code", d, 8'h5A);
    status(s); chk("R8 pending cleared", s & 8'h20, 8'h00);
    host_wr(3'd4, 8'h84); host_rd_data(d); chk("R8 second query", d, 8'h00);

    // R9 unknown command then data byte
    host_wr(3'd4, 8'h55); host_wr(3'd0, 8'h07); wait_ibf_clear();
    repeat (4) @(negedge clk);
    status(s); chk("R9 no output after unknown", s & 8'h01, 8'h00);

    // R11 stray data byte in idle
    host_wr(3'd0, 8'h08); wait_ibf_clear();
    repeat (4) @(negedge clk);
    status(s); chk("R11 stray data no output", s & 8'h01, 8'h00);
    ec_read(8'h08, d); chk("R11 register untouched", d, pat(8));

    // R10 command aborts a write sequence
    host_wr(3'd4, 8'h81); host_wr(3'd0, 8'h40);
    ec_read(8'h41, d); chk("R10 new command result", d, pat(65));
    ec_read(8'h40, d); chk("R10 aborted write left register", d, pat(64));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule